// File: doc/BRIEF.md
# Split-Range Tuning Word Normalizer

This block takes a tuning request and turns it into two codes for a pair of 16-bit DACs whose outputs are summed in analog. The fine DAC counts at 1/256 of the coarse DAC's weight, so the two ranges overlap. Together they give close to 24 bits of resolution. The block keeps the effective value `coarse*256 + fine` equal to the last request. It holds the coarse code still for as long as it can, because every coarse step can put a small glitch on the analog sum.

A request is normally met by moving only the fine code. The coarse code moves when the fine code needed to meet the request would fall outside a guard window. The window covers the fine DAC's usable span and excludes its ends. When that happens, a new coarse code is chosen that puts the fine code just at or above mid-scale. Each accepted request updates both codes together, one cycle later, with a strobe. A separate flag marks the updates in which the coarse code moved. During reset the codes are loaded from the request word present on the input.

Top module: `tune_split`

## Requirements
- R1: While `rst_n` is low, each clock loads the codes as a recentre of `req_word` (the same split as R5/R6), and `upd_stb` and `coarse_moved` read 0.
- R2: A request sampled with `req_valid` high at a rising edge appears on `coarse_code`/`fine_code` after that same edge, with `upd_stb` high for exactly that one cycle.
- R3: After every update, `coarse_code*256 + fine_code` equals the 24-bit request that caused it.
- R4: If `req_word - coarse_code*256` lies in the guard window 4096..61439 for the current coarse code, the coarse code is kept, only the fine code changes, and `coarse_moved` stays 0.
- R5: If the request is outside the window and is at least 32768, the new coarse code is `(req_word - 32768) >> 8`, so the fine code lands in 32768..33023.
- R6: If the request is outside the window and is below 32768, the coarse code becomes 0 and the fine code equals the request.
- R7: `coarse_moved` is 1 exactly on the update cycles in which the coarse code differs from its previous value. It is never high without `upd_stb`.
- R8: With `req_valid` low, both codes hold their values and `upd_stb` and `coarse_moved` are 0.
- R9: Both guard limits are inclusive. A fine offset of exactly 4096 or 61439 keeps the coarse code, and 4095 or 61440 moves it.
- R10: The top request 16777215 maps to coarse 65407 and fine 33023, and request 0 maps to coarse 0 and fine 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; loads codes from `req_word` |
| req_valid | input | 1 | Request present this cycle |
| req_word | input | 24 | Requested tuning value |
| coarse_code | output | 16 | Code for the coarse DAC |
| fine_code | output | 16 | Code for the fine DAC (weight 1/256) |
| upd_stb | output | 1 | Codes changed from a request this cycle |
| coarse_moved | output | 1 | Coarse code changed in this update |

## Verification
The bench drives requests exactly one count inside and one count outside each guard limit. A design that treats a limit as exclusive, or that is off by one, would either move the coarse code at the boundary or keep a fine code that has left the window. Requests below mid-scale check the floor case, where a wrong subtraction would wrap the coarse code to a huge value. The top request checks that the sum still equals the request with no overflow. Random walks of small steps, mixed with large jumps, check that small moves never disturb the coarse code. They also check that after a jump, the recentred fine code sits just at or above mid-scale and not at an edge of its range.

// File: rtl/tsn_pkg.sv
package tsn_pkg;

  // Default geometry of the DAC pair
  localparam int unsigned TSN_CW    = 16;     // coarse code width
  localparam int unsigned TSN_FW    = 16;     // fine code width
  localparam int unsigned TSN_SHIFT = 8;      // fine weight = 1 / 2**SHIFT
  localparam int unsigned TSN_LO    = 4096;   // lowest fine code kept
  localparam int unsigned TSN_HI    = 61439;  // highest fine code kept
  localparam int unsigned TSN_MID   = 32768;  // recentre target

  // How the next pair of codes was produced
  typedef enum logic [1:0] {
    SPLIT_KEEP     = 2'd0,  // fine-only move
    SPLIT_RECENTRE = 2'd1,  // coarse moved, fine near mid-scale
    SPLIT_FLOOR    = 2'd2   // request below mid-scale, coarse at zero
  } split_kind_e;

endpackage

// File: rtl/tsn_fine_window.sv
module tsn_fine_window #(
  parameter int unsigned CW    = tsn_pkg::TSN_CW,
  parameter int unsigned FW    = tsn_pkg::TSN_FW,
  parameter int unsigned SHIFT = tsn_pkg::TSN_SHIFT,
  parameter int unsigned LO    = tsn_pkg::TSN_LO,
  parameter int unsigned HI    = tsn_pkg::TSN_HI
) (
  input  logic [CW+SHIFT-1:0] req,
  input  logic [CW-1:0]       cur_coarse,
  output logic [FW-1:0]       fine_try,
  output logic                in_window
);
  localparam int unsigned RW = CW + SHIFT;
  localparam int unsigned DW = RW + 2;
  localparam logic signed [DW-1:0] LO_S = DW'(LO);
  localparam logic signed [DW-1:0] HI_S = DW'(HI);

  // Fine offset needed to meet req with the present coarse code (signed)
  function automatic logic signed [DW-1:0] fine_offset(
    input logic [RW-1:0] r,
    input logic [CW-1:0] c
  );
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    a = {2'b00, r};
    b = {2'b00, c, {SHIFT{1'b0}}};
    return $signed(a - b);
  endfunction

  logic signed [DW-1:0] offset;

  always_comb begin
    offset    = fine_offset(req, cur_coarse);
    in_window = (offset >= LO_S) && (offset <= HI_S);
    fine_try  = offset[FW-1:0];
  end

  // A kept fine code must itself sit inside the guard window (R4)
  always_comb begin
    if (in_window) begin
      assert_window_code_R4: assert ((FW'(LO) <= fine_try) && (fine_try <= FW'(HI)));
    end
  end

endmodule

// File: rtl/tsn_recentre.sv
module tsn_recentre
  import tsn_pkg::*;
#(
  parameter int unsigned CW    = tsn_pkg::TSN_CW,
  parameter int unsigned FW    = tsn_pkg::TSN_FW,
  parameter int unsigned SHIFT = tsn_pkg::TSN_SHIFT,
  parameter int unsigned MID   = tsn_pkg::TSN_MID
) (
  input  logic [CW+SHIFT-1:0] req,
  output logic [CW-1:0]       new_coarse,
  output logic [FW-1:0]       new_fine,
  output split_kind_e         kind
);
  localparam int unsigned RW = CW + SHIFT;
  localparam logic [RW-1:0] MID_R = RW'(MID);

  // Coarse code that leaves the fine code in [MID, MID + 2**SHIFT - 1]
  function automatic logic [CW-1:0] centre_coarse(input logic [RW-1:0] r);
    logic [RW-1:0] above;
    if (r < MID_R) return '0;
    above = r - MID_R;
    return above[RW-1:SHIFT];
  endfunction

  // Remainder carried by the fine DAC for a given coarse code
  function automatic logic [RW-1:0] remainder(
    input logic [RW-1:0] r,
    input logic [CW-1:0] c
  );
    return r - {c, {SHIFT{1'b0}}};
  endfunction

  logic [RW-1:0] rem;

  always_comb begin
    new_coarse = centre_coarse(req);
    rem        = remainder(req, new_coarse);
    new_fine   = rem[FW-1:0];
    kind       = (req < MID_R) ? SPLIT_FLOOR : SPLIT_RECENTRE;
  end

  // The remainder must fit the fine DAC, so the sum is exact (R3)
  always_comb begin
    assert_rem_fits_R3: assert ((rem >> FW) == '0);
  end

endmodule

// File: rtl/tune_split.sv
module tune_split
  import tsn_pkg::*;
#(
  parameter int unsigned CW    = tsn_pkg::TSN_CW,
  parameter int unsigned FW    = tsn_pkg::TSN_FW,
  parameter int unsigned SHIFT = tsn_pkg::TSN_SHIFT,
  parameter int unsigned LO    = tsn_pkg::TSN_LO,
  parameter int unsigned HI    = tsn_pkg::TSN_HI,
  parameter int unsigned MID   = tsn_pkg::TSN_MID
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [CW+SHIFT-1:0] req_word,
  output logic [CW-1:0]       coarse_code,
  output logic [FW-1:0]       fine_code,
  output logic                upd_stb,
  output logic                coarse_moved
);
  localparam int unsigned RW      = CW + SHIFT;
  localparam int unsigned SPAN    = 1 << SHIFT;
  localparam logic [FW-1:0] MID_F = FW'(MID);
  localparam logic [FW-1:0] TOP_F = FW'(MID + SPAN - 1);

  // Internal events, named for the assertions
  logic [FW-1:0] win_fine;
  logic          win_hit;
  logic [CW-1:0] rc_coarse;
  logic [FW-1:0] rc_fine;
  split_kind_e   rc_kind;
  split_kind_e   step_kind;
  logic [CW-1:0] coarse_next;
  logic [FW-1:0] fine_next;
  logic          move_next;

  logic [CW-1:0] coarse_q;
  logic [FW-1:0] fine_q;
  logic          stb_q;
  logic          moved_q;

  tsn_fine_window #(
    .CW(CW), .FW(FW), .SHIFT(SHIFT), .LO(LO), .HI(HI)
  ) u_window (
    .req        (req_word),
    .cur_coarse (coarse_q),
    .fine_try   (win_fine),
    .in_window  (win_hit)
  );

  tsn_recentre #(
    .CW(CW), .FW(FW), .SHIFT(SHIFT), .MID(MID)
  ) u_recentre (
    .req        (req_word),
    .new_coarse (rc_coarse),
    .new_fine   (rc_fine),
    .kind       (rc_kind)
  );

  // Choose the next pair: fine-only move when the window allows it
  always_comb begin
    if (win_hit) begin
      coarse_next = coarse_q;
      fine_next   = win_fine;
      step_kind   = SPLIT_KEEP;
    end else begin
      coarse_next = rc_coarse;
      fine_next   = rc_fine;
      step_kind   = rc_kind;
    end
    move_next = (coarse_next != coarse_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coarse_q <= rc_coarse;
      fine_q   <= rc_fine;
      stb_q    <= 1'b0;
      moved_q  <= 1'b0;
    end else begin
      stb_q   <= req_valid;
      moved_q <= req_valid && move_next;
      if (req_valid) begin
        coarse_q <= coarse_next;
        fine_q   <= fine_next;
      end
    end
  end

  assign coarse_code  = coarse_q;
  assign fine_code    = fine_q;
  assign upd_stb      = stb_q;
  assign coarse_moved = moved_q;

  // ---------------- assertions ----------------
  assert_sum_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> (({coarse_code, {SHIFT{1'b0}}} + RW'(fine_code)) == $past(req_word)));

  assert_keep_coarse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_hit) |=> (!coarse_moved && (coarse_code == $past(coarse_code))));

  assert_centre_fine_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !win_hit && (step_kind == SPLIT_RECENTRE))
      |=> ((fine_code >= MID_F) && (fine_code <= TOP_F)));

  assert_floor_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !win_hit && (step_kind == SPLIT_FLOOR))
      |=> ((coarse_code == '0) && (RW'(fine_code) == $past(req_word))));

  assert_moved_has_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_moved |-> (upd_stb && (coarse_code != $past(coarse_code))));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!upd_stb && !coarse_moved && $stable(coarse_code) && $stable(fine_code)));

endmodule

// File: tb/sim_tune_split.sv
module sim_tune_split;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_word = '0;
  logic [15:0] coarse_code;
  logic [15:0] fine_code;
  logic        upd_stb;
  logic        coarse_moved;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int mdl_c  = 0;   // bench's own record of the coarse code

  tune_split u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
    .coarse_code(coarse_code), .fine_code(fine_code),
    .upd_stb(upd_stb), .coarse_moved(coarse_moved)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected split, written from the requirements
  function automatic void expect_split(input int r, input int cur,
                                       output int c, output int f);
    int off;
    off = r - cur * 256;
    if (off >= 4096 && off <= 61439) begin c = cur; f = off; end
    else if (r >= 32768) begin c = (r - 32768) / 256; f = r - c * 256; end
    else begin c = 0; f = r; end
  endfunction

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // Drive one request and check the result one edge later
  task automatic send(input int r, input string tag);
    int ec, ef;
    expect_split(r, mdl_c, ec, ef);
    @(negedge clk);
    req_valid = 1'b1;
    req_word  = r[23:0];
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R2 strobe"}, int'(upd_stb), 1);
    chk({tag, " coarse"}, int'(coarse_code), ec);
    chk({tag, " fine"}, int'(fine_code), ef);
    chk({tag, " R3 sum"}, int'(coarse_code) * 256 + int'(fine_code), r);
    chk({tag, " R7 moved"}, int'(coarse_moved), int'(ec != mdl_c));
    mdl_c = ec;
  endtask

  initial begin
    int ec, ef;
    int base;
    void'($urandom(32'd1234));
    // R1: reset loads a recentre of the request on the input
    req_word = 24'h123456;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_split(24'h123456, -1000000, ec, ef);
    chk("R1 reset coarse", int'(coarse_code), ec);
    chk("R1 reset fine", int'(fine_code), ef);
    chk("R1 reset strobe", int'(upd_stb), 0);
    chk("R1 reset moved", int'(coarse_moved), 0);
    mdl_c = ec;
    rst_n = 1'b1;

    // R8: idle cycles hold everything
    repeat (4) @(negedge clk);
    chk("R8 idle coarse", int'(coarse_code), ec);
    chk("R8 idle fine", int'(fine_code), ef);
    chk("R8 idle strobe", int'(upd_stb), 0);

    // R2: strobe lasts one cycle
    send(mdl_c * 256 + 40000, "R4 keep");
    @(negedge clk);
    chk("R2 strobe drops", int'(upd_stb), 0);

    // R9: inclusive guard limits around the present coarse code
    base = mdl_c * 256;
    send(base + 4096, "R9 low edge keep");
    send(base + 61439, "R9 high edge keep");
    send(base + 61440, "R9 high edge move R5");
    base = mdl_c * 256;
    send(base + 4095, "R9 low edge move R5");

    // R6 / R10: ends of the range
    send(0, "R10 zero R6");
    send(20000, "R6 floor keep");
    send(1000, "R6 floor below guard");
    send(16777215, "R10 top");
    send(16777215 - 30000, "R4 near top");
    send(32768, "R5 mid");

    // Random walk: small steps and large jumps
    for (int i = 0; i < 400; i++) begin
      int r;
      if ($urandom_range(0, 3) == 0) r = int'($urandom_range(0, 16777215));
      else begin
        r = mdl_c * 256 + 32768 + int'($urandom_range(0, 65535)) - 32768;
        if (r < 0) r = 0;
        if (r > 16777215) r = 16777215;
      end
      send(r, "R4 R5 random");
      if ($urandom_range(0, 4) == 0) begin
        @(negedge clk);
        chk("R8 idle strobe random", int'(upd_stb), 0);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule